// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block drives the external memory bus of a classic 8-bit microcontroller core. Each external access takes one machine cycle. The low byte of the address goes out on a shared low port, and an address-latch pulse (`ale`) captures it into an outside latch. The same port then carries the data byte: the block drives it on a write and releases it on a read.

A second, high port carries the upper address byte for program fetches and for accesses through a 16-bit pointer. For accesses through an 8-bit pointer, the high port keeps showing its own port register. Separate active-low strobes mark data reads, data writes and code reads.

When no access is running, both ports drive their port registers and every strobe stays high. The latch pulse can run freely or only during external accesses.

The core raises `req_valid` together with the kind, direction, address and write data. It holds them until `req_accept` is seen. The access then runs over the next machine cycle. A read returns its byte on `rd_data`, which is valid from the clock where `acc_done` is high.

Top module: `xbus_ctl`

## Requirements
- R1: A request is taken only in the last clock (clock 11) of a 12-clock machine cycle, and `req_accept` is high there. The access fills clocks 0 to 11 of the next machine cycle. `acc_done` is high for exactly one clock, clock 10.
- R2: In clocks 0 to 2 of an access, the low port is driven with address bits 7:0. `ale` is high in clocks 0 and 1 and low in clock 2, so the address is still held when `ale` falls.
- R3: The high port shows address bits 15:8 for the whole access when the kind is fetch (`req_kind` = 0) or wide data (`req_kind` = 1). For narrow data (`req_kind` = 2 or 3), it shows the high port register, unchanged, for the whole access.
- R4: On a data write, the low port drives the write byte in clocks 3 to 10. `wr_n` is low in clocks 4 to 9 only and rises in clock 10, while the data is still driven.
- R5: On a read, the low port is released (`lo_oe` = 0) in clocks 3 to 10. The strobe is low in clocks 4 to 9: `rd_n` for data reads and `code_rd_n` for fetches. `lo_in` is captured on the edge where the strobe rises and appears on `rd_data` from clock 10.
- R6: A fetch is always a read. `req_write` has no effect on a fetch, and `wr_n` and `rd_n` stay high during it. At most one strobe is low at any time.
- R7: With `ale_only_ext` = 0, `ale` is high for 2 clocks out of every 6. The exception is a data access cycle, where the second pulse (clocks 6 and 7) is left out.
- R8: With `ale_only_ext` = 1, `ale` pulses only in clocks 0 and 1 of an access cycle. Between accesses it stays low.
- R9: During and after reset, both port registers hold FFh. Both ports drive FFh, every strobe is high and `ale` is low.
- R10: Between accesses, the ports drive their registers with `lo_oe` = 1 and every strobe stays high. A register write shows on the port one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ale_only_ext | input | 1 | 1: latch pulse only in access cycles |
| lo_reg_we | input | 1 | Write `reg_wdata` to the low port register |
| hi_reg_we | input | 1 | Write `reg_wdata` to the high port register |
| reg_wdata | input | 8 | Port register write data |
| req_valid | input | 1 | Access request |
| req_kind | input | 2 | 0 fetch, 1 wide data, 2/3 narrow data |
| req_write | input | 1 | 1 write, 0 read (data kinds only) |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| req_accept | output | 1 | Request taken this clock |
| acc_done | output | 1 | Access finishing, read data valid |
| rd_data | output | 8 | Captured read byte |
| lo_in | input | 8 | Low port pin values |
| lo_out | output | 8 | Low port drive value |
| lo_oe | output | 1 | Low port drive enable |
| hi_out | output | 8 | High port drive value |
| ale | output | 1 | Address latch enable |
| wr_n | output | 1 | Data write strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| code_rd_n | output | 1 | Code read strobe, active low |

## Verification
Wide-pointer and narrow-pointer accesses are run with a high port register that differs from the address upper byte. This shows which of the two sources the high port selects. Reads and writes are run with different data and pin bytes, so the drive and release windows, the strobe choice and the capture edge show up clock by clock. A fetch is requested with the write flag set, to show that the flag is ignored. The latch pulse is watched in both modes, both idle and inside fetch and data cycles, to separate the free-running pattern, the skipped pulse and the access-only pulse.

// File: rtl/xbus_ctl.sv
module xbus_ctl #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int STATE_CLKS = 2,
  parameter int STATES     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_only_ext,
  input  logic              lo_reg_we,
  input  logic              hi_reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_accept,
  output logic              acc_done,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] lo_in,
  output logic [DATA_W-1:0] lo_out,
  output logic              lo_oe,
  output logic [DATA_W-1:0] hi_out,
  output logic              ale,
  output logic              wr_n,
  output logic              rd_n,
  output logic              code_rd_n
);
  localparam int CYC = STATES * STATE_CLKS;
  localparam int CW  = $clog2(CYC);
  localparam logic [CW-1:0] C_LAST     = CW'(CYC - 1);
  localparam logic [CW-1:0] C_ALE_END  = CW'(STATE_CLKS);
  localparam logic [CW-1:0] C_ADDR_END = CW'(STATE_CLKS + STATE_CLKS / 2);
  localparam logic [CW-1:0] C_STB_BEG  = CW'(2 * STATE_CLKS);
  localparam logic [CW-1:0] C_STB_END  = CW'(5 * STATE_CLKS);
  localparam logic [CW-1:0] C_ALE2_BEG = CW'(3 * STATE_CLKS);
  localparam logic [CW-1:0] C_ALE2_END = CW'(4 * STATE_CLKS);
  localparam logic [1:0] K_FETCH = 2'd0;
  localparam logic [1:0] K_WIDE  = 2'd1;

  logic [CW-1:0]     cnt;
  logic              busy;
  logic [1:0]        q_kind;
  logic              q_wr;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_wdata;
  logic [DATA_W-1:0] lo_reg, hi_reg, rd_q;

  logic q_read, data_acc, in_addr, in_data, in_strobe, ale1, ale2;

  assign q_read    = !q_wr || (q_kind == K_FETCH);
  assign data_acc  = busy && (q_kind != K_FETCH);
  assign in_addr   = busy && (cnt < C_ADDR_END);
  assign in_data   = busy && (cnt >= C_ADDR_END) && (cnt <= C_STB_END);
  assign in_strobe = busy && (cnt >= C_STB_BEG) && (cnt < C_STB_END);
  assign ale1      = cnt < C_ALE_END;
  assign ale2      = (cnt >= C_ALE2_BEG) && (cnt < C_ALE2_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= C_LAST;
      busy    <= 1'b0;
      q_kind  <= K_FETCH;
      q_wr    <= 1'b0;
      q_addr  <= '0;
      q_wdata <= '0;
      lo_reg  <= '1;
      hi_reg  <= '1;
      rd_q    <= '0;
    end else begin
      cnt <= (cnt == C_LAST) ? '0 : cnt + CW'(1);
      if (cnt == C_LAST) begin
        busy <= req_valid;
        if (req_valid) begin
          q_kind  <= req_kind;
          q_wr    <= req_write;
          q_addr  <= req_addr;
          q_wdata <= req_wdata;
        end
      end
      if (lo_reg_we) lo_reg <= reg_wdata;
      if (hi_reg_we) hi_reg <= reg_wdata;
      if (busy && q_read && (cnt == C_STB_END - CW'(1))) rd_q <= lo_in;
    end
  end

  assign req_accept = req_valid && (cnt == C_LAST);
  assign acc_done   = busy && (cnt == C_STB_END);
  assign rd_data    = rd_q;

  assign lo_out = in_addr ? q_addr[DATA_W-1:0] :
                  (in_data && !q_read) ? q_wdata : lo_reg;
  assign lo_oe  = !(in_data && q_read);
  assign hi_out = (busy && (q_kind <= K_WIDE)) ? q_addr[ADDR_W-1 -: DATA_W] : hi_reg;

  assign wr_n      = !(in_strobe && data_acc && q_wr);
  assign rd_n      = !(in_strobe && data_acc && !q_wr);
  assign code_rd_n = !(in_strobe && busy && (q_kind == K_FETCH));

  assign ale = ale_only_ext ? (busy && ale1) : (ale1 || (ale2 && !data_acc));
endmodule

// File: rtl/xbus_ctl_chk.sv
module xbus_ctl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ale_only_ext,
  input logic              hi_reg_we,
  input logic              busy,
  input logic              narrow,
  input logic              ale,
  input logic              wr_n,
  input logic              rd_n,
  input logic              code_rd_n,
  input logic              lo_oe,
  input logic [DATA_W-1:0] lo_out,
  input logic [DATA_W-1:0] hi_out
);
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $fell(ale) && lo_oe) |-> ($stable(lo_out) && $stable(hi_out)));

  assert_narrow_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && narrow && $past(busy) && $past(narrow) && !$past(hi_reg_we)) |-> $stable(hi_out));

  assert_write_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> lo_oe);

  assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !code_rd_n) |-> !lo_oe);

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~wr_n, ~rd_n, ~code_rd_n}) <= 1);

  assert_ale_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_only_ext && !busy) |-> !ale);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (wr_n && rd_n && code_rd_n && lo_oe));
endmodule

bind xbus_ctl xbus_ctl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ale_only_ext(ale_only_ext), .hi_reg_we(hi_reg_we),
  .busy(busy), .narrow(q_kind[1]), .ale(ale), .wr_n(wr_n), .rd_n(rd_n),
  .code_rd_n(code_rd_n), .lo_oe(lo_oe), .lo_out(lo_out), .hi_out(hi_out)
);

// File: tb/test_xbus_ctl.sv
module test_xbus_ctl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, ale_only_ext, lo_reg_we, hi_reg_we, req_valid, req_write;
  logic [7:0] reg_wdata, req_wdata, lo_in;
  logic [1:0] req_kind;
  logic [15:0] req_addr;
  logic req_accept, acc_done, lo_oe, ale, wr_n, rd_n, code_rd_n;
  logic [7:0] rd_data, lo_out, hi_out;

  int vectors = 0;
  int fails = 0;
  logic [7:0] lo_r = 8'hFF;
  logic [7:0] hi_r = 8'hFF;

  xbus_ctl i_xbus_ctl (
    .clk(clk), .rst_n(rst_n), .ale_only_ext(ale_only_ext), .lo_reg_we(lo_reg_we),
    .hi_reg_we(hi_reg_we), .reg_wdata(reg_wdata), .req_valid(req_valid),
    .req_kind(req_kind), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_accept(req_accept), .acc_done(acc_done),
    .rd_data(rd_data), .lo_in(lo_in), .lo_out(lo_out), .lo_oe(lo_oe),
    .hi_out(hi_out), .ale(ale), .wr_n(wr_n), .rd_n(rd_n), .code_rd_n(code_rd_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  task automatic t_reset();
    rst_n = 1'b0; ale_only_ext = 1'b0; lo_reg_we = 1'b0; hi_reg_we = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; reg_wdata = '0; req_wdata = '0;
    req_kind = '0; req_addr = '0; lo_in = '0;
    repeat (4) @(negedge clk);
    // R9: reset state
    chk(lo_out == 8'hFF && lo_oe, "R9 lo port", int'(lo_out), 8'hFF);
    chk(hi_out == 8'hFF, "R9 hi port", int'(hi_out), 8'hFF);
    chk(wr_n && rd_n && code_rd_n, "R9 strobes", int'({wr_n, rd_n, code_rd_n}), 7);
    chk(!ale, "R9 ale", int'(ale), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_idle_regs();
    @(negedge clk);
    lo_reg_we = 1'b1; hi_reg_we = 1'b1; reg_wdata = 8'h3C;
    @(negedge clk);
    hi_reg_we = 1'b0; reg_wdata = 8'hC3; lo_reg_we = 1'b0; hi_reg_we = 1'b1;
    @(negedge clk);
    hi_reg_we = 1'b0;
    lo_r = 8'h3C; hi_r = 8'hC3;
    // R10: register writes reach the ports, strobes stay high
    chk(lo_out == lo_r && lo_oe, "R10 lo reg", int'(lo_out), int'(lo_r));
    chk(hi_out == hi_r, "R10 hi reg", int'(hi_out), int'(hi_r));
    chk(wr_n && rd_n && code_rd_n, "R10 strobes", int'({wr_n, rd_n, code_rd_n}), 7);
  endtask

  task automatic t_ale_idle(input bit restr);
    int rises = 0;
    int highs = 0;
    logic prev;
    ale_only_ext = restr;
    @(negedge clk);
    prev = ale;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (ale && !prev) rises++;
      if (ale) highs++;
      prev = ale;
    end
    if (restr) begin
      chk(highs == 0, "R8 idle ale", highs, 0);
    end else begin
      chk(rises == 4, "R7 ale rises", rises, 4);
      chk(highs == 8, "R7 ale high clocks", highs, 8);
    end
  endtask

  task automatic t_access(input logic [1:0] kind, input bit wr, input logic [15:0] addr,
                          input logic [7:0] wd, input logic [7:0] din, input bit restr);
    bit is_fetch = (kind == 2'd0);
    bit is_read = is_fetch || !wr;
    bit strobe_t;
    logic [7:0] hi_exp;
    logic [7:0] lo_exp;
    bit ale_exp;
    ale_only_ext = restr;
    hi_exp = (kind <= 2'd1) ? addr[15:8] : hi_r;
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_write = wr; req_addr = addr;
    req_wdata = wd; lo_in = din;
    while (!req_accept) @(negedge clk);
    chk(req_accept, "R1 accept", int'(req_accept), 1);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i == 0) req_valid = 1'b0;
      strobe_t = (i >= 4 && i <= 9);
      // R2, R7, R8: latch pulse
      ale_exp = restr ? (i < 2) : ((i < 2) || (is_fetch && (i == 6 || i == 7)));
      chk(ale == ale_exp, restr ? "R8 ale in access" : "R7 ale in access", int'(ale), int'(ale_exp));
      // R3: high port source
      chk(hi_out == hi_exp, "R3 hi port", int'(hi_out), int'(hi_exp));
      // R1: done pulse position
      chk(acc_done == (i == 10), "R1 done", int'(acc_done), int'(i == 10));
      // R4, R5, R6: strobes
      chk(wr_n == !(strobe_t && !is_read), "R4 wr_n", int'(wr_n), int'(!(strobe_t && !is_read)));
      chk(rd_n == !(strobe_t && !is_fetch && is_read), "R5 rd_n", int'(rd_n),
          int'(!(strobe_t && !is_fetch && is_read)));
      chk(code_rd_n == !(strobe_t && is_fetch), "R6 code_rd_n", int'(code_rd_n),
          int'(!(strobe_t && is_fetch)));
      // R2, R4, R5: low port
      if (i < 3) begin
        chk(lo_oe && lo_out == addr[7:0], "R2 addr low", int'(lo_out), int'(addr[7:0]));
      end else if (i <= 10) begin
        if (is_read) chk(!lo_oe, "R5 release", int'(lo_oe), 0);
        else chk(lo_oe && lo_out == wd, "R4 write data", int'(lo_out), int'(wd));
      end else begin
        lo_exp = lo_r;
        chk(lo_oe && lo_out == lo_exp, "R10 lo after", int'(lo_out), int'(lo_exp));
      end
      if (i == 10 && is_read) chk(rd_data == din, "R5 read data", int'(rd_data), int'(din));
    end
  endtask

  initial begin
    t_reset();
    t_idle_regs();
    t_ale_idle(1'b0);
    t_ale_idle(1'b1);
    t_access(2'd1, 1'b1, 16'h12A5, 8'h69, 8'h00, 1'b0);
    t_access(2'd1, 1'b0, 16'h8001, 8'h00, 8'hB7, 1'b0);
    t_access(2'd2, 1'b0, 16'h0044, 8'h00, 8'h1E, 1'b0);
    t_access(2'd3, 1'b1, 16'h5577, 8'hA2, 8'h00, 1'b0);
    t_access(2'd0, 1'b1, 16'hF00D, 8'h11, 8'h5C, 1'b0);
    t_access(2'd0, 1'b0, 16'h0ACE, 8'h00, 8'hE4, 1'b1);
    t_access(2'd1, 1'b0, 16'hBEEF, 8'h00, 8'h42, 1'b1);
    t_access(2'd2, 1'b1, 16'h9933, 8'h7E, 8'h00, 1'b1);
    t_ale_idle(1'b1);
    t_ale_idle(1'b0);
    report();
  end
endmodule